// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block produces the per-stage hold and squash controls for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. It looks at the instruction codes in the decode, execute and memory pipeline registers. It also looks at the two source register IDs of the decode instruction, the register that the execute instruction will load into, and the branch outcome from the execute stage. From these it tells the F, D and E pipeline registers whether to hold their contents (stall) or to load a no-op (bubble) at the next rising clock edge. The block has no state. Every output is a pure function of the current inputs.

The unit recognises three triggers:

- **Load/use hazard.** A memory load or pop in execute writes a register that the decode instruction reads.
- **Mispredicted jump.** Every conditional jump is fetched as taken, so a jump that turns out not taken is a misprediction.
- **Return in flight.** A return sits in decode, execute or memory.

When triggers coincide, a fixed priority applies. A load/use hazard overrides the decode squash that a return would request. A misprediction whose target is a return is handled as a misprediction. The M and W registers always advance, so they receive no controls from this unit.

Top module: `hazard_ctrl`

## Requirements
- R1: When the execute code equals the load code (default 5) or the pop code (default 11), and its load destination equals decode source A or decode source B, the unit drives the following: F stall = 1, D stall = 1, D bubble = 0, E bubble = 1.
- R2: The register ID 8 means "no register". A load destination of 8 never produces a hazard, even when a decode source is also 8.
- R3: When the execute code equals the jump code (default 7) and the taken flag is 0, D bubble and E bubble are 1 and F stall is 0.
- R4: A jump in execute with the taken flag 1 asserts no control. The taken flag has no effect unless a jump is in execute.
- R5: When the return code (default 9) is in the decode, execute or memory code input, and no other trigger is present, the unit drives F stall = 1, D bubble = 1, D stall = 0 and E bubble = 0.
- R6: When a return is in flight and a load/use hazard is also present, the load/use controls of R1 are driven unchanged, with no D bubble. In a pipeline, the return therefore stays in decode for one extra cycle and is then squashed behind.
- R7: When a return is in flight and a misprediction is also present, the unit drives F stall = 1, D bubble = 1 and E bubble = 1, with no D stall.
- R8: No register is ever given stall and bubble together.
- R9: F bubble and E stall are always 0. With no trigger present, all six outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_icode | input | 4 | Instruction code in the decode register |
| e_icode | input | 4 | Instruction code in the execute register |
| m_icode | input | 4 | Instruction code in the memory register |
| e_ld_dst | input | 4 | Register that the execute instruction loads from memory (8 = none) |
| d_src_a | input | 4 | First decode source register ID (8 = none) |
| d_src_b | input | 4 | Second decode source register ID (8 = none) |
| e_taken | input | 1 | The execute-stage jump condition holds |
| f_stall | output | 1 | Hold the fetch register |
| f_bubble | output | 1 | Squash the fetch register (always 0) |
| d_stall | output | 1 | Hold the decode register |
| d_bubble | output | 1 | Load a no-op into the decode register |
| e_stall | output | 1 | Hold the execute register (always 0) |
| e_bubble | output | 1 | Load a no-op into the execute register |

## Verification
The assertions are checked whenever the inputs change. They confirm that no register is ever told to both stall and bubble. They also tie the action pattern of each detected trigger to the resolved outputs, and they check that a load/use hazard removes the decode squash of a return. Some behaviour can only be shown by the bench's scenarios, because it needs exact input codes or a running pipeline:

- the exact match conditions, including the no-register ID;
- the absence of action for a taken jump;
- the three stage positions of a return;
- the extra cycle that a return spends in decode behind a load.

// File: rtl/hctl_pkg.sv
package hctl_pkg;

    // Controls for one pipeline register.
    typedef struct packed {
        logic stall;
        logic bubble;
    } reg_ctl_t;

    // Which triggers are present in this cycle.
    typedef struct packed {
        logic load_use;
        logic mispredict;
        logic ret_busy;
    } trig_t;

endpackage

// File: rtl/hctl_loaduse_det.sv
module hctl_loaduse_det #(
    parameter int                 ICODE_W = 4,
    parameter int                 REG_W   = 4,
    parameter logic [ICODE_W-1:0] C_LOAD  = 4'd5,
    parameter logic [ICODE_W-1:0] C_POP   = 4'd11,
    parameter logic [REG_W-1:0]   NO_REG  = 4'd8
) (
    input  logic [ICODE_W-1:0] e_icode,
    input  logic [REG_W-1:0]   e_ld_dst,
    input  logic [REG_W-1:0]   d_src_a,
    input  logic [REG_W-1:0]   d_src_b,
    output logic               hit
);
    logic is_load;
    logic dst_real;
    logic src_match;

    always_comb begin
        is_load   = (e_icode == C_LOAD) || (e_icode == C_POP);
        dst_real  = (e_ld_dst != NO_REG);
        src_match = (e_ld_dst == d_src_a) || (e_ld_dst == d_src_b);
        hit       = is_load && dst_real && src_match;
    end
endmodule

// File: rtl/hctl_mispredict_det.sv
module hctl_mispredict_det #(
    parameter int                 ICODE_W = 4,
    parameter logic [ICODE_W-1:0] C_JUMP  = 4'd7
) (
    input  logic [ICODE_W-1:0] e_icode,
    input  logic               e_taken,
    output logic               hit
);
    always_comb hit = (e_icode == C_JUMP) && !e_taken;
endmodule

// File: rtl/hctl_ret_det.sv
module hctl_ret_det #(
    parameter int                 ICODE_W = 4,
    parameter int                 N_STG   = 3,
    parameter logic [ICODE_W-1:0] C_RET   = 4'd9
) (
    input  logic [N_STG-1:0][ICODE_W-1:0] stg_icode,
    output logic                          hit
);
    logic [N_STG-1:0] per_stg;

    for (genvar s = 0; s < N_STG; s++) begin : g_stg
        assign per_stg[s] = (stg_icode[s] == C_RET);
    end

    assign hit = |per_stg;
endmodule

// File: rtl/hctl_resolve.sv
module hctl_resolve
    import hctl_pkg::*;
(
    input  trig_t    trig,
    output reg_ctl_t f_ctl,
    output reg_ctl_t d_ctl,
    output reg_ctl_t e_ctl
);
    always_comb begin
        f_ctl.stall  = trig.load_use || trig.ret_busy;
        f_ctl.bubble = 1'b0;

        d_ctl.stall  = trig.load_use;
        // A load/use hazard keeps the return in decode instead of squashing it.
        d_ctl.bubble = trig.mispredict || (trig.ret_busy && !trig.load_use);

        e_ctl.stall  = 1'b0;
        e_ctl.bubble = trig.mispredict || trig.load_use;
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hctl_pkg::*;
#(
    parameter int                 ICODE_W = 4,
    parameter int                 REG_W   = 4,
    parameter logic [ICODE_W-1:0] C_LOAD  = 4'd5,
    parameter logic [ICODE_W-1:0] C_POP   = 4'd11,
    parameter logic [ICODE_W-1:0] C_JUMP  = 4'd7,
    parameter logic [ICODE_W-1:0] C_RET   = 4'd9,
    parameter logic [REG_W-1:0]   NO_REG  = 4'd8
) (
    input  logic [ICODE_W-1:0] d_icode,
    input  logic [ICODE_W-1:0] e_icode,
    input  logic [ICODE_W-1:0] m_icode,
    input  logic [REG_W-1:0]   e_ld_dst,
    input  logic [REG_W-1:0]   d_src_a,
    input  logic [REG_W-1:0]   d_src_b,
    input  logic               e_taken,
    output logic               f_stall,
    output logic               f_bubble,
    output logic               d_stall,
    output logic               d_bubble,
    output logic               e_stall,
    output logic               e_bubble
);
    localparam int N_RET_STG = 3;

    trig_t    trig;
    reg_ctl_t f_ctl, d_ctl, e_ctl;
    logic [N_RET_STG-1:0][ICODE_W-1:0] ret_codes;

    assign ret_codes = {m_icode, e_icode, d_icode};

    hctl_loaduse_det #(
        .ICODE_W(ICODE_W), .REG_W(REG_W),
        .C_LOAD(C_LOAD), .C_POP(C_POP), .NO_REG(NO_REG)
    ) lu_i (
        .e_icode (e_icode),
        .e_ld_dst(e_ld_dst),
        .d_src_a (d_src_a),
        .d_src_b (d_src_b),
        .hit     (trig.load_use)
    );

    hctl_mispredict_det #(
        .ICODE_W(ICODE_W), .C_JUMP(C_JUMP)
    ) mp_i (
        .e_icode(e_icode),
        .e_taken(e_taken),
        .hit    (trig.mispredict)
    );

    hctl_ret_det #(
        .ICODE_W(ICODE_W), .N_STG(N_RET_STG), .C_RET(C_RET)
    ) rt_i (
        .stg_icode(ret_codes),
        .hit      (trig.ret_busy)
    );

    hctl_resolve res_i (
        .trig (trig),
        .f_ctl(f_ctl),
        .d_ctl(d_ctl),
        .e_ctl(e_ctl)
    );

    assign f_stall  = f_ctl.stall;
    assign f_bubble = f_ctl.bubble;
    assign d_stall  = d_ctl.stall;
    assign d_bubble = d_ctl.bubble;
    assign e_stall  = e_ctl.stall;
    assign e_bubble = e_ctl.bubble;

    always_comb begin
        // R8
        no_dual_f_chk: assert (!(f_stall && f_bubble));
        // R8
        no_dual_d_chk: assert (!(d_stall && d_bubble));
        // R8
        no_dual_e_chk: assert (!(e_stall && e_bubble));
        // R1
        lu_action_chk: assert (!trig.load_use || (f_stall && d_stall && e_bubble));
        // R3
        mp_action_chk: assert (!trig.mispredict || (d_bubble && e_bubble && !d_stall));
        // R6
        lu_over_ret_chk: assert (!(trig.load_use && trig.ret_busy) || !d_bubble);
        // R5
        ret_action_chk: assert (!(trig.ret_busy && !trig.load_use && !trig.mispredict)
                                || (f_stall && d_bubble && !e_bubble));
        // R9
        idle_quiet_chk: assert ((trig != '0) ||
                                !(f_stall || d_stall || d_bubble || e_bubble));
    end
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb_top;
    localparam logic [3:0] NOP = 4'd1, OP = 4'd6, LD = 4'd5, POP = 4'd11,
                           JMP = 4'd7, RET = 4'd9, NR = 4'd8;
    localparam int NV = 15;

    // Vector fields: tag, d, e, m, dst, srcA, srcB, taken, expected {fs, fb, ds, db, es, eb}.
    localparam logic [34:0] VEC [NV] = '{
        {4'd9, NOP, NOP, NOP, NR, NR, NR, 1'b0, 6'b000000}, // R9 idle
        {4'd1, OP,  LD,  NOP, 4'd2, 4'd2, NR, 1'b0, 6'b101001}, // R1 load hits source A
        {4'd1, OP,  POP, NOP, 4'd3, NR, 4'd3, 1'b0, 6'b101001}, // R1 pop hits source B
        {4'd1, OP,  LD,  NOP, 4'd2, 4'd3, 4'd4, 1'b0, 6'b000000}, // R1 no match
        {4'd2, OP,  LD,  NOP, NR, NR, NR, 1'b0, 6'b000000}, // R2 no-register ID
        {4'd1, OP,  OP,  NOP, 4'd2, 4'd2, 4'd2, 1'b0, 6'b000000}, // R1 non-load writer
        {4'd3, OP,  JMP, NOP, NR, NR, NR, 1'b0, 6'b000101}, // R3 not taken
        {4'd4, OP,  JMP, NOP, NR, NR, NR, 1'b1, 6'b000000}, // R4 taken
        {4'd5, RET, NOP, NOP, NR, NR, NR, 1'b0, 6'b100100}, // R5 return in D
        {4'd5, NOP, RET, NOP, NR, NR, NR, 1'b0, 6'b100100}, // R5 return in E
        {4'd5, NOP, NOP, RET, NR, NR, NR, 1'b0, 6'b100100}, // R5 return in M
        {4'd6, RET, LD,  NOP, 4'd4, 4'd4, NR, 1'b0, 6'b101001}, // R6 return in D behind load
        {4'd7, RET, JMP, NOP, NR, NR, NR, 1'b0, 6'b100101}, // R7 return at jump target
        {4'd6, OP,  LD,  RET, 4'd2, 4'd2, NR, 1'b0, 6'b101001}, // R6 return in M with hazard
        {4'd4, NOP, NOP, NOP, NR, NR, NR, 1'b1, 6'b000000}  // R4 flag without jump
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int checks = 0, errors = 0;

    logic [3:0] v_d, v_e, v_m, v_dst, v_a, v_b;
    logic       v_t;
    logic       use_model = 1'b0;

    // Pipeline register model honouring the stall and bubble controls.
    logic [3:0] f_in, d_q, e_q, m_q;
    logic [3:0] d_i, e_i, m_i, dst_i, a_i, b_i;
    logic       t_i;
    logic       f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble;

    always_comb begin
        if (use_model) begin
            d_i = d_q; e_i = e_q; m_i = m_q;
            dst_i = (e_q == LD) ? 4'd4 : NR;
            a_i   = (d_q == RET) ? 4'd4 : NR;
            b_i = NR; t_i = 1'b1;
        end else begin
            d_i = v_d; e_i = v_e; m_i = v_m;
            dst_i = v_dst; a_i = v_a; b_i = v_b; t_i = v_t;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= NOP; e_q <= NOP; m_q <= NOP;
        end else begin
            m_q <= e_q;
            e_q <= e_bubble ? NOP : (e_stall ? e_q : d_q);
            d_q <= d_bubble ? NOP : (d_stall ? d_q : f_in);
        end
    end

    hazard_ctrl dut_i (
        .d_icode(d_i), .e_icode(e_i), .m_icode(m_i),
        .e_ld_dst(dst_i), .d_src_a(a_i), .d_src_b(b_i), .e_taken(t_i),
        .f_stall(f_stall), .f_bubble(f_bubble), .d_stall(d_stall),
        .d_bubble(d_bubble), .e_stall(e_stall), .e_bubble(e_bubble)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {2'b00, f_stall, f_bubble, d_stall, d_bubble, e_stall, e_bubble};
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        v_d = NOP; v_e = NOP; v_m = NOP; v_dst = NR; v_a = NR; v_b = NR; v_t = 1'b0;
        f_in = NOP;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9 reset outputs", outs(), 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            v_d = VEC[i][30:27]; v_e = VEC[i][26:23]; v_m = VEC[i][22:19];
            v_dst = VEC[i][18:15]; v_a = VEC[i][14:11]; v_b = VEC[i][10:7];
            v_t = VEC[i][6];
            #2;
            chk($sformatf("R%0d vector %0d", VEC[i][34:31], i), outs(), {2'b00, VEC[i][5:0]});
        end

        // R6 scenario: load followed by a return that reads its destination.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        use_model = 1'b1;
        f_in = LD;
        @(negedge clk);            // D = load
        f_in = RET;
        @(negedge clk);            // D = return, E = load: hazard present
        f_in = OP;
        chk("R6 hazard controls", outs(), 8'b00101001);
        @(negedge clk);            // return held, E squashed
        chk("R6 return held in D", {4'h0, d_q}, {4'h0, RET});
        chk("R6 E bubble after hazard", {4'h0, e_q}, {4'h0, NOP});
        chk("R5 return squash controls", outs(), 8'b00100100);
        @(negedge clk);            // return in E, D squashed
        chk("R5 return moved to E", {4'h0, e_q}, {4'h0, RET});
        chk("R5 D squashed", {4'h0, d_q}, {4'h0, NOP});
        @(negedge clk);            // return in M
        chk("R5 return in M still squashes", outs(), 8'b00100100);
        @(negedge clk);            // return in W: pipeline released
        chk("R9 released after return", outs(), 8'h00);
        @(negedge clk);
        chk("R5 fetch resumes", {4'h0, d_q}, {4'h0, OP});

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule